// File: doc/BRIEF.md
# Host Event Latch and Query Encoder

This block gathers event requests from up to `N_EVT` independent sources into one pending word. Each source raises its event with a single-cycle set pulse. The pending bit then stays set until one of two things clears it: an explicit clear operation that carries a bit mask, or a query. A query reports the lowest-order pending event and removes only that event.

Three mask registers choose which pending events reach three level outputs. These are the system-management request, the system-control request and the wake request. Each mask can be written and read back on a small register port. The outputs are combinational functions of the registered pending word and the registered masks.

The query is a valid/ready stream. A request is accepted when `qry_valid` and `qry_ready` are both high. The answer appears on `rsp_code` with `rsp_valid` in the next cycle and is held until `rsp_ready` is high. `qry_ready` is high when no answer is held, or when the held answer is being taken in the same cycle. Event codes start at 1, so a code of 0 means that nothing was pending.

Top module: `evt_pend_unit`

## Requirements
- R1: After reset the pending word is empty, all three masks read back zero, the three request outputs are low and `rsp_valid` is low.
- R2: A set pulse on `evt_set[n-1]` makes event code n pending from the next cycle, and the event stays pending until a clear or a query removes it.
- R3: An accepted query returns, in the next cycle, the 1-based index of the lowest-order pending bit. Bit 0 gives 1 and bit N_EVT-1 gives N_EVT.
- R4: An accepted query with no pending event returns code 0.
- R5: An accepted query clears exactly the bit it reported and leaves every other pending bit unchanged.
- R6: Mask select 0 is the system-management mask, 1 is the system-control mask and 2 is the wake mask. A write with select 3 changes no mask, and a read with select 3 returns zero.
- R7: A clear operation (`clr_en` high) removes every pending bit that is set in `clr_mask`.
- R8: When a set pulse and a clear or a query clear hit the same bit in the same cycle, the bit is pending afterwards.
- R9: Each request output is high exactly when at least one pending event is enabled in its mask.
- R10: A response is held with the same code while `rsp_valid` is high and `rsp_ready` is low. During that time `qry_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | N_EVT | One set pulse per event, bit n-1 for code n |
| clr_en | input | 1 | Apply clear operation this cycle |
| clr_mask | input | N_EVT | Pending bits to clear |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_sel | input | 2 | Mask select for write |
| mask_wr_data | input | N_EVT | Mask write value |
| mask_rd_sel | input | 2 | Mask select for read |
| mask_rd_data | output | N_EVT | Selected mask value |
| qry_valid | input | 1 | Query request |
| qry_ready | output | 1 | Query can be accepted |
| rsp_valid | output | 1 | Query answer present |
| rsp_ready | input | 1 | Answer taken |
| rsp_code | output | $clog2(N_EVT+1) | 1-based event code, 0 for none |
| smi_req | output | 1 | Management request |
| sci_req | output | 1 | Control request |
| wake_req | output | 1 | Wake request |

## Verification
The bench builds the block with the default of 32 events, so the code output is 6 bits wide. At this size the extreme codes are reachable: bit 31 gives code 32, and code 0 means an empty word. The directed phase reaches both extremes, as well as set-versus-clear collisions on one bit and a query that collides with a set on the bit it reports. A random phase then mixes mask writes, clears, queries and responses that are held back, and compares every cycle against a behavioural model.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    MSEL_SMI  = 2'd0,
    MSEL_SCI  = 2'd1,
    MSEL_WAKE = 2'd2,
    MSEL_NONE = 2'd3
  } msel_e;

  localparam int NUM_MASK = 3;
endpackage

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int N_EVT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [N_EVT-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [N_EVT-1:0] rd_data,
  output logic [N_EVT-1:0] smi_mask,
  output logic [N_EVT-1:0] sci_mask,
  output logic [N_EVT-1:0] wake_mask
);
  import evt_pkg::*;

  logic [N_EVT-1:0] mask_q [NUM_MASK];

  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[g] <= '0;
      end else if (wr_en && (wr_sel == 2'(g))) begin
        mask_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (msel_e'(rd_sel))
      MSEL_SMI:  rd_data = mask_q[0];
      MSEL_SCI:  rd_data = mask_q[1];
      MSEL_WAKE: rd_data = mask_q[2];
      default:   rd_data = '0;
    endcase
  end

  assign smi_mask  = mask_q[0];
  assign sci_mask  = mask_q[1];
  assign wake_mask = mask_q[2];
endmodule

// File: rtl/evt_lowest_enc.sv
module evt_lowest_enc #(
  parameter int N_EVT  = 32,
  parameter int CODE_W = $clog2(N_EVT + 1)
) (
  input  logic [N_EVT-1:0]  vec,
  output logic [CODE_W-1:0] code,
  output logic [N_EVT-1:0]  onehot
);
  // isolate lowest set bit by two's complement
  assign onehot = vec & (~vec + N_EVT'(1));

  always_comb begin
    code = '0;
    for (int i = N_EVT - 1; i >= 0; i--) begin
      if (vec[i]) code = CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/evt_pend_reg.sv
module evt_pend_reg #(
  parameter int N_EVT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_vec,
  input  logic [N_EVT-1:0] clr_vec,
  output logic [N_EVT-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | set_vec;  // set has priority
  end
endmodule

// File: rtl/evt_pend_unit.sv
module evt_pend_unit #(
  parameter int N_EVT  = 32,
  parameter int CODE_W = $clog2(N_EVT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_set,
  input  logic              clr_en,
  input  logic [N_EVT-1:0]  clr_mask,
  input  logic              mask_wr_en,
  input  logic [1:0]        mask_wr_sel,
  input  logic [N_EVT-1:0]  mask_wr_data,
  input  logic [1:0]        mask_rd_sel,
  output logic [N_EVT-1:0]  mask_rd_data,
  input  logic              qry_valid,
  output logic              qry_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CODE_W-1:0] rsp_code,
  output logic              smi_req,
  output logic              sci_req,
  output logic              wake_req
);
  logic [N_EVT-1:0]  pend_q;
  logic [N_EVT-1:0]  smi_mask, sci_mask, wake_mask;
  logic [N_EVT-1:0]  low_onehot, clr_vec;
  logic [CODE_W-1:0] low_code;
  logic              qry_acc;

  evt_mask_bank #(.N_EVT(N_EVT)) u_masks (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mask_wr_en), .wr_sel(mask_wr_sel), .wr_data(mask_wr_data),
    .rd_sel(mask_rd_sel), .rd_data(mask_rd_data),
    .smi_mask(smi_mask), .sci_mask(sci_mask), .wake_mask(wake_mask)
  );

  evt_lowest_enc #(.N_EVT(N_EVT), .CODE_W(CODE_W)) u_enc (
    .vec(pend_q), .code(low_code), .onehot(low_onehot)
  );

  assign qry_ready = !rsp_valid || rsp_ready;
  assign qry_acc   = qry_valid && qry_ready;
  assign clr_vec   = (clr_en ? clr_mask : '0) | (qry_acc ? low_onehot : '0);

  evt_pend_reg #(.N_EVT(N_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_vec(evt_set), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
    end else if (qry_acc) begin
      rsp_valid <= 1'b1;
      rsp_code  <= low_code;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign smi_req  = |(pend_q & smi_mask);
  assign sci_req  = |(pend_q & sci_mask);
  assign wake_req = |(pend_q & wake_mask);
endmodule

// File: rtl/evt_pend_unit_chk.sv
module evt_pend_unit_chk #(
  parameter int N_EVT  = 32,
  parameter int CODE_W = $clog2(N_EVT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EVT-1:0]  evt_set,
  input logic              clr_en,
  input logic [N_EVT-1:0]  pend_q,
  input logic              qry_valid,
  input logic              qry_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [CODE_W-1:0] rsp_code,
  input logic              smi_req,
  input logic              sci_req,
  input logic              wake_req
);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((pend_q & $past(evt_set)) == $past(evt_set)));

  // R3
  rsp_follows_qry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ready) |=> rsp_valid);

  // R4
  empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ready && (pend_q == '0)) |=> (rsp_code == '0));

  // R5
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_ready && !clr_en) |=> ($countones($past(pend_q) & ~pend_q) <= 1));

  // R9
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (!smi_req && !sci_req && !wake_req));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)));

  // R10
  no_accept_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !qry_ready);
endmodule

bind evt_pend_unit evt_pend_unit_chk #(.N_EVT(N_EVT), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .clr_en(clr_en),
  .pend_q(pend_q), .qry_valid(qry_valid), .qry_ready(qry_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
  .smi_req(smi_req), .sci_req(sci_req), .wake_req(wake_req)
);

// File: tb/evt_pend_unit_tb.sv
module evt_pend_unit_tb;
  localparam int CLK_P  = 10;
  localparam int N      = 32;
  localparam int CW     = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_set = '0, clr_mask = '0, mask_wr_data = '0, mask_rd_data;
  logic clr_en = 1'b0, mask_wr_en = 1'b0;
  logic [1:0] mask_wr_sel = '0, mask_rd_sel = '0;
  logic qry_valid = 1'b0, qry_ready, rsp_valid, rsp_ready = 1'b1;
  logic [CW-1:0] rsp_code;
  logic smi_req, sci_req, wake_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_pend_unit #(.N_EVT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .clr_en(clr_en),
    .clr_mask(clr_mask), .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel),
    .mask_wr_data(mask_wr_data), .mask_rd_sel(mask_rd_sel),
    .mask_rd_data(mask_rd_data), .qry_valid(qry_valid), .qry_ready(qry_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .smi_req(smi_req), .sci_req(sci_req), .wake_req(wake_req)
  );

  // behavioural reference state
  logic [N-1:0] m_pend;
  logic [N-1:0] m_msk [3];
  logic m_rv;
  int   m_rc;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [N-1:0] rd_exp;
    rd_exp = (mask_rd_sel == 2'd3) ? '0 : m_msk[mask_rd_sel];
    chk("R6 mask readback", mask_rd_data, rd_exp);
    chk("R9 smi_req", smi_req, |(m_pend & m_msk[0]));
    chk("R9 sci_req", sci_req, |(m_pend & m_msk[1]));
    chk("R9 wake_req", wake_req, |(m_pend & m_msk[2]));
    chk("R10 rsp_valid", rsp_valid, m_rv);
    chk("R10 qry_ready", qry_ready, !m_rv || rsp_ready);
    if (m_rv) chk("R3 rsp_code", rsp_code, m_rc);
  endtask

  task automatic step();
    logic [N-1:0] np;
    logic nrv;
    int nrc;
    logic qacc;
    qacc = qry_valid && (!m_rv || rsp_ready);
    np = m_pend & ~(clr_en ? clr_mask : '0);
    nrv = m_rv && !rsp_ready;
    nrc = m_rc;
    if (qacc) begin
      nrv = 1'b1;
      nrc = 0;
      for (int i = 0; i < N; i++) begin
        if (m_pend[i]) begin
          nrc = i + 1;
          np[i] = 1'b0;
          break;
        end
      end
    end
    np = np | evt_set;
    @(posedge clk);
    m_pend = np;
    m_rv = nrv;
    m_rc = nrc;
    if (mask_wr_en && mask_wr_sel != 2'd3) m_msk[mask_wr_sel] = mask_wr_data;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    evt_set = '0; clr_en = 0; clr_mask = '0; mask_wr_en = 0;
    qry_valid = 0; rsp_ready = 1;
  endtask

  task automatic wmask(int sel, logic [N-1:0] v);
    mask_wr_en = 1; mask_wr_sel = 2'(sel); mask_wr_data = v;
    step(); idle();
  endtask

  task automatic query(int exp, string req);
    qry_valid = 1; step(); idle();
    chk(req, rsp_code, exp);
    step();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_pend = '0; m_msk[0] = '0; m_msk[1] = '0; m_msk[2] = '0; m_rv = 0; m_rc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      mask_rd_sel = 2'(s); #1;
      chk("R1 mask zero", mask_rd_data, 0);
    end
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 requests", {smi_req, sci_req, wake_req}, 0);
    step();
    query(0, "R1 empty after reset");

    // R6 mask writes and readback
    wmask(0, 32'h0000_0001);
    wmask(1, 32'h8000_0010);
    wmask(2, 32'h0000_FF00);
    wmask(3, 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      mask_rd_sel = 2'(s); step();
      chk("R6 readback", mask_rd_data,
          s == 0 ? 32'h1 : s == 1 ? 32'h8000_0010 : s == 2 ? 32'hFF00 : 0);
    end

    // R2 / R9 / R3 / R4 / R5
    evt_set = 32'h8000_0010; step(); idle();
    chk("R9 sci raised", sci_req, 1);
    chk("R2 smi not raised", smi_req, 0);
    step(); step();
    chk("R2 still pending", sci_req, 1);
    query(5, "R3 lowest code 5");
    chk("R5 bit31 kept", sci_req, 1);
    query(32, "R3 top code 32");
    chk("R5 empty", sci_req, 0);
    query(0, "R4 none pending");

    evt_set = 32'h1; step(); idle();
    chk("R9 smi raised", smi_req, 1);
    query(1, "R3 code 1");

    // R10 back-pressure
    evt_set = 32'h0000_0300; step(); idle();
    chk("R9 wake raised", wake_req, 1);
    rsp_ready = 0; qry_valid = 1; step();
    qry_valid = 1; step(); step();
    chk("R10 held code", rsp_code, 9);
    chk("R10 no accept", qry_ready, 0);
    qry_valid = 0; rsp_ready = 1; step(); idle();
    query(10, "R10 second query after release");

    // R7 clear operation
    evt_set = 32'h0000_000F; step(); idle();
    clr_en = 1; clr_mask = 32'h5; step(); idle();
    query(2, "R7 cleared bits skipped");
    query(4, "R7 remaining bit");

    // R8 set beats clear
    evt_set = 32'h80; clr_en = 1; clr_mask = '1; step(); idle();
    query(8, "R8 set over clear");
    evt_set = 32'h200; step(); idle();
    evt_set = 32'h200; qry_valid = 1; step(); idle();
    chk("R8 query code", rsp_code, 10);
    step();
    query(10, "R8 set over query clear");

    // random mix against model
    for (int c = 0; c < 600; c++) begin
      evt_set     = $urandom & $urandom & $urandom;
      clr_en      = ($urandom % 8) == 0;
      clr_mask    = $urandom;
      mask_wr_en  = ($urandom % 6) == 0;
      mask_wr_sel = 2'($urandom);
      mask_wr_data = $urandom;
      mask_rd_sel = 2'($urandom);
      qry_valid   = ($urandom % 3) == 0;
      rsp_ready   = ($urandom % 4) != 0;
      step();
    end
    idle();
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule